// File: doc/BRIEF.md
# MMU Control and Fault Register Bank

This block is the set of configuration and fault-reporting registers that sit beside an address-translation unit. Software reaches it through a small register-number interface: a write strobe, a register number, write data and a combinational read-data return. It keeps the translation control word, the physical base of the first-level translation table, and the per-domain access control word. Its outputs feed the permission checker and the table walker. Neither of those is part of this block.

Two register numbers behave differently on a write. Writing the fault-status number stores nothing. Instead it raises a one-cycle command that empties the whole translation buffer. Writing the fault-address number also stores nothing. It raises a one-cycle command that invalidates a single buffer entry, and it presents the written data as the virtual address to drop. A fault capture port records the domain, the access type, the internal/external flag and the virtual address of each data abort. Aborts on instruction prefetch leave the fault registers untouched.

Top module: `mmu_ctl_regs`

## Requirements
- R1: Register number 1 stores the low CTL_W bits (default 8) of the write data. A read returns them with the upper bits zero, and bit 0 of the stored word drives `xlate_en`.
- R2: Register number 2 stores the table base. A read and the `table_base` output always show bits [13:0] as zero, whatever was written.
- R3: Register number 3 stores a full 32-bit domain access word. Domain n owns bits [2n+1:2n], and the word appears unchanged on `domain_ctl`.
- R4: A write to register number 5 raises `tlb_flush` in the same cycle as the write, for that cycle only. It does not change the fault status.
- R5: A write to register number 6 raises `tlb_purge` in the same cycle as the write, with `purge_vaddr` equal to the write data. It does not change the fault address.
- R6: A data fault (`fault_valid`=1, `fault_is_data`=1) sets the fault status and the fault address after the next clock edge. The status is domain in bits [7:4], access type in bits [3:1] and external flag in bit 0, read back on register 5. The address reads back on register 6.
- R7: A prefetch fault (`fault_valid`=1, `fault_is_data`=0) leaves both fault registers unchanged.
- R8: Register numbers other than 1, 2, 3, 5 and 6 read as zero. Writes to them change no register and raise no command.
- R9: Reset clears the control word (so `xlate_en` is 0), the table base, the domain word and both fault registers.
- R10: `tlb_flush` and `tlb_purge` are never high together, and neither is raised without a write strobe. A read never raises them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_num | input | 4 | Register number for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `reg_num` |
| fault_valid | input | 1 | An abort is being reported this cycle |
| fault_is_data | input | 1 | 1 = data access, 0 = instruction prefetch |
| fault_domain | input | 4 | Domain number of the faulting access |
| fault_type | input | 3 | Encoded access/fault type |
| fault_external | input | 1 | 1 = external fault, 0 = internal |
| fault_vaddr | input | 32 | Virtual address of the faulting access |
| xlate_en | output | 1 | Translation enable, control bit 0 |
| ctl_word | output | 8 | Stored control word |
| table_base | output | 32 | Translation table base, low 14 bits zero |
| domain_ctl | output | 32 | Domain access control word |
| tlb_flush | output | 1 | One-cycle full buffer flush command |
| tlb_purge | output | 1 | One-cycle single-entry purge command |
| purge_vaddr | output | 32 | Virtual address to purge, valid with `tlb_purge` |

## Verification
A decode error shows at the ports in the same cycle as the write. In that cycle either a command pulse is missing or a spurious one appears, or data lands in the wrong register and reads back wrong one cycle later. If fault capture were qualified wrongly, a single prefetch abort would overwrite the status and address that software reads next. The bench therefore follows each data abort with a prefetch abort. It also writes to the two command register numbers and reads back afterwards, so that a stored value shows up as a changed fault register.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
  localparam int REG_NUM_W = 4;
  typedef logic [REG_NUM_W-1:0] reg_num_t;

  // register numbers; software depends on these values
  localparam reg_num_t REG_CTL = 4'd1;
  localparam reg_num_t REG_TTB = 4'd2;
  localparam reg_num_t REG_DAC = 4'd3;
  localparam reg_num_t REG_FSR = 4'd5;
  localparam reg_num_t REG_FAR = 4'd6;

  // fault status layout is architectural: domain[7:4], type[3:1], ext[0]
  localparam int DOM_W   = 4;
  localparam int FTYPE_W = 3;
  localparam int FSR_W   = DOM_W + FTYPE_W + 1;

  function automatic logic [FSR_W-1:0] fsr_pack(
    input logic [DOM_W-1:0]   dom,
    input logic [FTYPE_W-1:0] typ,
    input logic               ext
  );
    return {dom, typ, ext};
  endfunction
endpackage

// File: rtl/mmu_reg_decode.sv
module mmu_reg_decode
  import mmu_regs_pkg::*;
(
  input  logic     reg_wr,
  input  reg_num_t reg_num,
  output logic     hit_ctl,
  output logic     hit_ttb,
  output logic     hit_dac,
  output logic     hit_fsr,
  output logic     hit_far
);
  always_comb begin
    hit_ctl = 1'b0;
    hit_ttb = 1'b0;
    hit_dac = 1'b0;
    hit_fsr = 1'b0;
    hit_far = 1'b0;
    if (reg_wr) begin
      unique case (reg_num)
        REG_CTL: hit_ctl = 1'b1;
        REG_TTB: hit_ttb = 1'b1;
        REG_DAC: hit_dac = 1'b1;
        REG_FSR: hit_fsr = 1'b1;
        REG_FAR: hit_far = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mmu_cfg_store.sv
module mmu_cfg_store #(
  parameter int DATA_W    = 32,
  parameter int CTL_W     = 8,
  parameter int TTB_ALIGN = 14,
  localparam int TTB_KEEP = DATA_W - TTB_ALIGN
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit_ctl,
  input  logic                hit_ttb,
  input  logic                hit_dac,
  input  logic [CTL_W-1:0]    ctl_in,
  input  logic [TTB_KEEP-1:0] ttb_in,
  input  logic [DATA_W-1:0]   dac_in,
  output logic [CTL_W-1:0]    ctl_q,
  output logic [TTB_KEEP-1:0] ttb_q,
  output logic [DATA_W-1:0]   dac_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      ttb_q <= '0;
      dac_q <= '0;
    end else begin
      if (hit_ctl) ctl_q <= ctl_in;
      if (hit_ttb) ttb_q <= ttb_in;
      if (hit_dac) dac_q <= dac_in;
    end
  end
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import mmu_regs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_valid,
  input  logic               fault_is_data,
  input  logic [DOM_W-1:0]   fault_domain,
  input  logic [FTYPE_W-1:0] fault_type,
  input  logic               fault_external,
  input  logic [DATA_W-1:0]  fault_vaddr,
  output logic               capture,
  output logic [FSR_W-1:0]   fsr_q,
  output logic [DATA_W-1:0]  far_q
);
  assign capture = fault_valid && fault_is_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else if (capture) begin
      fsr_q <= fsr_pack(fault_domain, fault_type, fault_external);
      far_q <= fault_vaddr;
    end
  end
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
  import mmu_regs_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CTL_W     = 8,
  parameter int TTB_ALIGN = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [REG_NUM_W-1:0] reg_num,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 fault_valid,
  input  logic                 fault_is_data,
  input  logic [DOM_W-1:0]     fault_domain,
  input  logic [FTYPE_W-1:0]   fault_type,
  input  logic                 fault_external,
  input  logic [DATA_W-1:0]    fault_vaddr,
  output logic                 xlate_en,
  output logic [CTL_W-1:0]     ctl_word,
  output logic [DATA_W-1:0]    table_base,
  output logic [DATA_W-1:0]    domain_ctl,
  output logic                 tlb_flush,
  output logic                 tlb_purge,
  output logic [DATA_W-1:0]    purge_vaddr
);
  localparam int TTB_KEEP = DATA_W - TTB_ALIGN;

  logic hit_ctl, hit_ttb, hit_dac, hit_fsr, hit_far;
  logic capture;
  logic [CTL_W-1:0]    ctl_q;
  logic [TTB_KEEP-1:0] ttb_q;
  logic [DATA_W-1:0]   dac_q;
  logic [FSR_W-1:0]    fsr_q;
  logic [DATA_W-1:0]   far_q;

  mmu_reg_decode u_dec (
    .reg_wr  (reg_wr),
    .reg_num (reg_num),
    .hit_ctl (hit_ctl),
    .hit_ttb (hit_ttb),
    .hit_dac (hit_dac),
    .hit_fsr (hit_fsr),
    .hit_far (hit_far)
  );

  mmu_cfg_store #(
    .DATA_W    (DATA_W),
    .CTL_W     (CTL_W),
    .TTB_ALIGN (TTB_ALIGN)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_ctl (hit_ctl),
    .hit_ttb (hit_ttb),
    .hit_dac (hit_dac),
    .ctl_in  (wr_data[CTL_W-1:0]),
    .ttb_in  (wr_data[DATA_W-1:TTB_ALIGN]),
    .dac_in  (wr_data),
    .ctl_q   (ctl_q),
    .ttb_q   (ttb_q),
    .dac_q   (dac_q)
  );

  mmu_fault_capture #(.DATA_W(DATA_W)) u_flt (
    .clk            (clk),
    .rst_n          (rst_n),
    .fault_valid    (fault_valid),
    .fault_is_data  (fault_is_data),
    .fault_domain   (fault_domain),
    .fault_type     (fault_type),
    .fault_external (fault_external),
    .fault_vaddr    (fault_vaddr),
    .capture        (capture),
    .fsr_q          (fsr_q),
    .far_q          (far_q)
  );

  // command pulses exist only in the cycle of the write strobe
  assign tlb_flush   = hit_fsr;
  assign tlb_purge   = hit_far;
  assign purge_vaddr = wr_data;

  assign xlate_en   = ctl_q[0];
  assign ctl_word   = ctl_q;
  assign table_base = {ttb_q, {TTB_ALIGN{1'b0}}};
  assign domain_ctl = dac_q;

  always_comb begin
    unique case (reg_num)
      REG_CTL: rd_data = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
      REG_TTB: rd_data = table_base;
      REG_DAC: rd_data = dac_q;
      REG_FSR: rd_data = {{(DATA_W-FSR_W){1'b0}}, fsr_q};
      REG_FAR: rd_data = far_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/mmu_ctl_regs_chk.sv
module mmu_ctl_regs_chk
  import mmu_regs_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CTL_W     = 8,
  parameter int TTB_ALIGN = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               hit_ctl,
  input logic               hit_ttb,
  input logic               hit_fsr,
  input logic               hit_far,
  input logic               capture,
  input logic               fault_valid,
  input logic               fault_is_data,
  input logic [DOM_W-1:0]   fault_domain,
  input logic [FTYPE_W-1:0] fault_type,
  input logic               fault_external,
  input logic [DATA_W-1:0]  fault_vaddr,
  input logic [CTL_W-1:0]   ctl_q,
  input logic [DATA_W-1:0]  table_base,
  input logic [FSR_W-1:0]   fsr_q,
  input logic [DATA_W-1:0]  far_q,
  input logic               tlb_flush,
  input logic               tlb_purge
);
  a_r1_ctl_store: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctl |=> ctl_q == $past(wr_data[CTL_W-1:0]));

  a_r2_ttb_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ttb |=> table_base == {$past(wr_data[DATA_W-1:TTB_ALIGN]), {TTB_ALIGN{1'b0}}});

  a_r4_flush_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_fsr && !capture) |=> $stable(fsr_q));

  a_r5_purge_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_far && !capture) |=> $stable(far_q));

  a_r6_data_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_is_data) |=>
      (far_q == $past(fault_vaddr)) &&
      (fsr_q == {$past(fault_domain), $past(fault_type), $past(fault_external)}));

  a_r7_prefetch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !fault_is_data) |=> $stable(fsr_q) && $stable(far_q));

  a_r10_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tlb_flush, tlb_purge}));

  a_r10_cmd_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_flush || tlb_purge) |-> reg_wr);
endmodule

bind mmu_ctl_regs mmu_ctl_regs_chk #(
  .DATA_W    (DATA_W),
  .CTL_W     (CTL_W),
  .TTB_ALIGN (TTB_ALIGN)
) u_chk (.*);

// File: tb/mmu_ctl_regs_bench.sv
module mmu_ctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_num = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        fault_valid = 1'b0;
  logic        fault_is_data = 1'b0;
  logic [3:0]  fault_domain = '0;
  logic [2:0]  fault_type = '0;
  logic        fault_external = 1'b0;
  logic [31:0] fault_vaddr = '0;
  logic        xlate_en;
  logic [7:0]  ctl_word;
  logic [31:0] table_base, domain_ctl, purge_vaddr;
  logic        tlb_flush, tlb_purge;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mmu_ctl_regs u_mmu_ctl_regs (.*);

  // {register number, write data, expected read-back}
  localparam int NVEC = 11;
  localparam logic [67:0] VEC [NVEC] = '{
    {4'd1,  32'hFFFF_FFFF, 32'h0000_00FF},   // R1
    {4'd2,  32'hFFFF_FFFF, 32'hFFFF_C000},   // R2
    {4'd3,  32'hA5A5_1234, 32'hA5A5_1234},   // R3
    {4'd0,  32'h1234_5678, 32'h0000_0000},   // R8
    {4'd4,  32'h1234_5678, 32'h0000_0000},   // R8
    {4'd7,  32'h1234_5678, 32'h0000_0000},   // R8
    {4'd15, 32'h1234_5678, 32'h0000_0000},   // R8
    {4'd5,  32'hDEAD_BEEF, 32'h0000_0000},   // R4
    {4'd6,  32'hCAFE_F00D, 32'h0000_0000},   // R5
    {4'd1,  32'h0000_0155, 32'h0000_0055},   // R1
    {4'd2,  32'h1234_5678, 32'h1234_4000}    // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drives a write for one cycle; samples the command outputs mid-cycle
  task automatic do_write(input logic [3:0] n, input logic [31:0] d,
                          output logic fl, output logic pu, output logic [31:0] pv);
    @(negedge clk);
    reg_wr = 1'b1; reg_num = n; wr_data = d;
    #1;
    fl = tlb_flush; pu = tlb_purge; pv = purge_vaddr;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] n, output logic [31:0] v);
    @(negedge clk);
    reg_num = n;
    #1;
    v = rd_data;
  endtask

  task automatic do_fault(input logic is_data, input logic [3:0] dom,
                          input logic [2:0] typ, input logic ext, input logic [31:0] va);
    @(negedge clk);
    fault_valid = 1'b1; fault_is_data = is_data; fault_domain = dom;
    fault_type = typ; fault_external = ext; fault_vaddr = va;
    @(negedge clk);
    fault_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, pv;
    logic fl, pu;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    do_read(4'd1, v); chk("R9 ctl after reset", v, 32'h0);
    chk("R9 xlate_en after reset", {31'b0, xlate_en}, 32'h0);
    do_read(4'd2, v); chk("R9 ttb after reset", v, 32'h0);
    do_read(4'd3, v); chk("R9 dac after reset", v, 32'h0);
    do_read(4'd5, v); chk("R9 fsr after reset", v, 32'h0);
    do_read(4'd6, v); chk("R9 far after reset", v, 32'h0);

    // table walk: write then read back (R1 R2 R3 R4 R5 R8)
    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i][67:64], VEC[i][63:32], fl, pu, pv);
      do_read(VEC[i][67:64], v);
      chk($sformatf("vector %0d reg %0d readback", i, VEC[i][67:64]), v, VEC[i][31:0]);
    end
    chk("R1 xlate_en follows bit0", {31'b0, xlate_en}, 32'h1);
    chk("R2 table_base output", table_base, 32'h1234_4000);
    chk("R3 domain 15 field", {30'b0, domain_ctl[31:30]}, 32'h2);
    chk("R3 domain 0 field", {30'b0, domain_ctl[1:0]}, 32'h0);

    // R8: writes to unlisted numbers leave everything alone
    for (int n = 0; n < 16; n++) begin
      if (n == 0 || n == 4 || n >= 7) begin
        do_write(n[3:0], 32'hFFFF_FFFF, fl, pu, pv);
        chk("R8 no command on unlisted write", {30'b0, fl, pu}, 32'h0);
      end
    end
    do_read(4'd1, v); chk("R8 ctl unchanged", v, 32'h55);
    do_read(4'd2, v); chk("R8 ttb unchanged", v, 32'h1234_4000);
    do_read(4'd3, v); chk("R8 dac unchanged", v, 32'hA5A5_1234);

    // R4: flush pulse in write cycle only
    do_write(4'd5, 32'h0000_00FF, fl, pu, pv);
    chk("R4 flush raised", {31'b0, fl}, 32'h1);
    chk("R10 no purge with flush", {31'b0, pu}, 32'h0);
    #1;
    chk("R4 flush gone next cycle", {31'b0, tlb_flush}, 32'h0);
    do_read(4'd5, v); chk("R4 fsr not written", v, 32'h0);

    // R6: data fault capture, fsr = {dom 9, type 5, ext 1} = 0x9B
    do_fault(1'b1, 4'd9, 3'd5, 1'b1, 32'h8765_4321);
    do_read(4'd5, v); chk("R6 fsr captured", v, 32'h0000_009B);
    do_read(4'd6, v); chk("R6 far captured", v, 32'h8765_4321);

    // R7: prefetch fault ignored
    do_fault(1'b0, 4'd3, 3'd2, 1'b0, 32'h1111_1111);
    do_read(4'd5, v); chk("R7 fsr kept", v, 32'h0000_009B);
    do_read(4'd6, v); chk("R7 far kept", v, 32'h8765_4321);

    // R5: purge pulse carries the address; far untouched
    do_write(4'd6, 32'h0040_1000, fl, pu, pv);
    chk("R5 purge raised", {31'b0, pu}, 32'h1);
    chk("R5 purge address", pv, 32'h0040_1000);
    chk("R10 no flush with purge", {31'b0, fl}, 32'h0);
    do_read(4'd6, v); chk("R5 far not written", v, 32'h8765_4321);

    // R4 again with a non-zero status
    do_write(4'd5, 32'h0000_0000, fl, pu, pv);
    do_read(4'd5, v); chk("R4 fsr kept over flush", v, 32'h0000_009B);

    // R10: read of command numbers raises nothing
    do_read(4'd5, v); chk("R10 no flush on read", {31'b0, tlb_flush}, 32'h0);
    do_read(4'd6, v); chk("R10 no purge on read", {31'b0, tlb_purge}, 32'h0);

    // R9: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_read(4'd1, v); chk("R9 ctl cleared", v, 32'h0);
    chk("R9 xlate_en cleared", {31'b0, xlate_en}, 32'h0);
    do_read(4'd3, v); chk("R9 dac cleared", v, 32'h0);
    do_read(4'd5, v); chk("R9 fsr cleared", v, 32'h0);
    do_read(4'd6, v); chk("R9 far cleared", v, 32'h0);

    finish_run();
  end
endmodule